// File: doc/BRIEF.md
# Single-Wire Bus Master Slot Timer

This block is the physical layer of a master on a single open-drain data line with an external pull-up resistor. Higher logic hands it one operation at a time: a bus reset with presence detection, a slot that writes a 1, a slot that writes a 0, a slot that reads one bit from a slave, or a strong pull-up hold. The block drives an active-low pull-down enable and samples a synchronised copy of the line at fixed points. For a reset it returns whether a slave answered, and for a read slot it returns the bit read. It also has a separate enable for an external strong pull-up transistor, used to power slaves during long internal operations.

Every duration is a whole number of microseconds. A prescaler turns the `CLK_HZ` parameter into a one-microsecond tick, so each phase lasts exactly its microsecond count times `CLK_HZ/1e6` clock cycles. Requests use a valid/ready handshake. `req_ready` is high only while the engine is idle and the synchronised line reads high. The master holds `req_valid` and the request fields steady until it sees `req_ready`, and the request is taken on the edge where both are high. Any request offered while `req_ready` is low is dropped. The result comes back on `done` as a single-cycle pulse with no back-pressure, so the consumer must take `rx_bit` in that cycle.

Top module: `swire_phy`

## Requirements
- R1: After reset: `bus_pd_n`=1 (line released), `spu_en`=0, `busy`=0, `done`=0, and `req_ready`=1 once the line reads high.
- R2: A request is taken only when `req_valid` and `req_ready` are both high. `req_ready` is low while `busy` is high or while the synchronised line is low. A request offered while `req_ready` is low starts nothing: `busy` stays low or the running operation finishes alone, and no extra `done` pulse appears.
- R3: Operation code 0 (reset): the line is pulled low for 480 µs, then released for 480 µs. `rx_bit` is 1 when the line reads low 70 µs after the release (a slave answered), and 0 otherwise.
- R4: Operation code 2 (write 1): the line is pulled low for 6 µs. The whole slot, from the falling edge to the end of `busy`, lasts 70 µs.
- R5: Operation code 1 (write 0): the line is pulled low for 60 µs. The whole slot lasts 70 µs.
- R6: Operation code 3 (read): the line is pulled low for 2 µs. It is sampled just before 12 µs after the falling edge, and `rx_bit` equals the level seen. The whole slot lasts 70 µs.
- R7: Any operation code with bit 2 set (hold): `spu_en` is high for `req_hold_us` µs while the line stays released. A hold of 0 µs gives `spu_en` for one cycle.
- R8: `done` is a one-cycle pulse and rises in the cycle where `busy` falls. `rx_bit` is valid with `done`, and it is 0 for write and hold operations.
- R9: `bus_pd_n`=0 and `spu_en`=1 never occur together.
- R10: A phase of N µs lasts exactly N×`CLK_HZ`/1,000,000 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at `CLK_HZ` |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle and line high; the request is taken when both are high |
| req_op | input | 3 | 0 reset, 1 write 0, 2 write 1, 3 read, bit 2 set = hold |
| req_hold_us | input | HOLD_W | Strong pull-up hold time in µs |
| done | output | 1 | One-cycle completion pulse |
| rx_bit | output | 1 | Presence flag or read bit, valid with `done` |
| busy | output | 1 | Operation in progress |
| bus_in | input | 1 | Raw line level (asynchronous) |
| bus_pd_n | output | 1 | Active-low pull-down enable for the open-drain driver |
| spu_en | output | 1 | Strong pull-up enable |

## Verification
The bench builds the block with `CLK_HZ` = 4 MHz and `HOLD_W` = 8, so one microsecond is four cycles. At this rate the full 960 µs reset sequence fits in a few thousand cycles, and each phase length can be checked against its exact cycle count, not against a tolerance. `SYNC_STAGES` keeps its default of 2, so the sample points are checked with the real synchroniser delay between the line and the sampling register. A modelled slave answers resets with a presence pulse and pulls the line low to answer reads with 0; it can be disabled to test the no-presence case.

// File: rtl/swire_pkg.sv
package swire_pkg;
  localparam logic [2:0] OP_RESET = 3'd0;
  localparam logic [2:0] OP_WR0   = 3'd1;
  localparam logic [2:0] OP_WR1   = 3'd2;
  localparam logic [2:0] OP_READ  = 3'd3;
  localparam logic [2:0] OP_HOLD  = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOW,
    ST_REL,
    ST_HOLD
  } swire_st_e;
endpackage

// File: rtl/swire_sync.sv
module swire_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES <= 1) begin : g_one
      logic r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= 1'b1;
        else        r <= d;
      end
      assign q = r;
    end else begin : g_chain
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '1;
        else        sh <= {sh[STAGES-2:0], d};
      end
      assign q = sh[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/swire_usclk.sv
module swire_usclk #(
  parameter int CYC_PER_US = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int PW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam logic [PW-1:0] LAST = PW'(CYC_PER_US - 1);

  logic [PW-1:0] pre;

  assign tick = (pre == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pre <= '0;
    else if (clr)  pre <= '0;
    else if (tick) pre <= '0;
    else           pre <= pre + 1'b1;
  end
endmodule

// File: rtl/swire_seq.sv
module swire_seq
  import swire_pkg::*;
#(
  parameter int HOLD_W      = 20,
  parameter int RST_LOW_US  = 480,
  parameter int RST_WAIT_US = 480,
  parameter int PRES_SMP_US = 70,
  parameter int W1_LOW_US   = 6,
  parameter int W0_LOW_US   = 60,
  parameter int RD_LOW_US   = 2,
  parameter int RD_SMP_US   = 12,
  parameter int SLOT_US     = 70
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line_hi,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [HOLD_W-1:0] req_hold_us,
  output logic              req_ready,
  output logic              clr,
  output logic              bus_pd_n,
  output logic              spu_en,
  output logic              busy,
  output logic              done,
  output logic              rx_bit
);
  localparam int US_W = (HOLD_W > 10) ? HOLD_W : 10;
  localparam logic [US_W-1:0] L_RST_LO = US_W'(RST_LOW_US);
  localparam logic [US_W-1:0] L_RST_RL = US_W'(RST_WAIT_US);
  localparam logic [US_W-1:0] L_PRES   = US_W'(PRES_SMP_US);
  localparam logic [US_W-1:0] L_W1_LO  = US_W'(W1_LOW_US);
  localparam logic [US_W-1:0] L_W1_RL  = US_W'(SLOT_US - W1_LOW_US);
  localparam logic [US_W-1:0] L_W0_LO  = US_W'(W0_LOW_US);
  localparam logic [US_W-1:0] L_W0_RL  = US_W'(SLOT_US - W0_LOW_US);
  localparam logic [US_W-1:0] L_RD_LO  = US_W'(RD_LOW_US);
  localparam logic [US_W-1:0] L_RD_RL  = US_W'(SLOT_US - RD_LOW_US);
  localparam logic [US_W-1:0] L_RD_SMP = US_W'(RD_SMP_US - RD_LOW_US);

  swire_st_e         st;
  logic [2:0]        op_q;
  logic [US_W-1:0]   hold_q;
  logic [US_W-1:0]   us;
  logic [US_W-1:0]   lim_lo, lim_rl, lim_smp, lim;
  logic              smp_en, end_c, smp_hit, accept;

  assign busy      = (st != ST_IDLE);
  assign req_ready = !busy && line_hi;
  assign accept    = req_valid && req_ready;
  assign bus_pd_n  = (st != ST_LOW);
  assign spu_en    = (st == ST_HOLD);

  always_comb begin
    lim_lo  = '0;
    lim_rl  = '0;
    lim_smp = '0;
    smp_en  = 1'b0;
    case (op_q)
      OP_RESET: begin lim_lo = L_RST_LO; lim_rl = L_RST_RL; lim_smp = L_PRES; smp_en = 1'b1; end
      OP_WR0:   begin lim_lo = L_W0_LO;  lim_rl = L_W0_RL; end
      OP_WR1:   begin lim_lo = L_W1_LO;  lim_rl = L_W1_RL; end
      OP_READ:  begin lim_lo = L_RD_LO;  lim_rl = L_RD_RL; lim_smp = L_RD_SMP; smp_en = 1'b1; end
      default:  begin lim_lo = '0; lim_rl = '0; end
    endcase
    case (st)
      ST_LOW:  lim = lim_lo;
      ST_REL:  lim = lim_rl;
      default: lim = hold_q;
    endcase
  end

  assign end_c   = (lim == '0) || (tick && (us == lim - 1'b1));
  assign smp_hit = (st == ST_REL) && smp_en && tick && (us == lim_smp - 1'b1);
  assign clr     = accept || ((st == ST_LOW) && end_c);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     us <= '0;
    else if (clr)   us <= '0;
    else if (tick)  us <= us + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      op_q   <= OP_RESET;
      hold_q <= '0;
      done   <= 1'b0;
      rx_bit <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (accept) begin
          op_q   <= req_op[2] ? OP_HOLD : req_op;
          hold_q <= US_W'(req_hold_us);
          rx_bit <= 1'b0;
          st     <= req_op[2] ? ST_HOLD : ST_LOW;
        end
        ST_LOW: if (end_c) st <= ST_REL;
        ST_REL: begin
          if (smp_hit) rx_bit <= (op_q == OP_RESET) ? !line_hi : line_hi;
          if (end_c) begin
            st   <= ST_IDLE;
            done <= 1'b1;
          end
        end
        default: if (end_c) begin
          st   <= ST_IDLE;
          done <= 1'b1;
        end
      endcase
    end
  end

  // R2: a refused request leaves the engine idle
  a_r2_refused_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && !req_ready) |=> !busy);
  // R2: work starts only from an accepted handshake
  a_r2_start_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid && req_ready));
  // R7: strong pull-up only during an operation
  a_r7_spu_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    spu_en |-> busy);
  // R8: done is one cycle wide
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8: done coincides with end of busy
  a_r8_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R9: pull-down and strong pull-up exclusive
  a_r9_no_fight: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_pd_n && spu_en));
endmodule

// File: rtl/swire_phy.sv
module swire_phy #(
  parameter int CLK_HZ      = 50_000_000,
  parameter int HOLD_W      = 20,
  parameter int SYNC_STAGES = 2,
  parameter int RST_LOW_US  = 480,
  parameter int RST_WAIT_US = 480,
  parameter int PRES_SMP_US = 70,
  parameter int W1_LOW_US   = 6,
  parameter int W0_LOW_US   = 60,
  parameter int RD_LOW_US   = 2,
  parameter int RD_SMP_US   = 12,
  parameter int SLOT_US     = 70
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [HOLD_W-1:0] req_hold_us,
  output logic              done,
  output logic              rx_bit,
  output logic              busy,
  input  logic              bus_in,
  output logic              bus_pd_n,
  output logic              spu_en
);
  localparam int CYC_PER_US = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;

  logic line_hi, tick, clr;

  swire_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_in), .q(line_hi)
  );

  swire_usclk #(.CYC_PER_US(CYC_PER_US)) u_usclk (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick)
  );

  swire_seq #(
    .HOLD_W(HOLD_W), .RST_LOW_US(RST_LOW_US), .RST_WAIT_US(RST_WAIT_US),
    .PRES_SMP_US(PRES_SMP_US), .W1_LOW_US(W1_LOW_US), .W0_LOW_US(W0_LOW_US),
    .RD_LOW_US(RD_LOW_US), .RD_SMP_US(RD_SMP_US), .SLOT_US(SLOT_US)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line_hi(line_hi),
    .req_valid(req_valid), .req_op(req_op), .req_hold_us(req_hold_us),
    .req_ready(req_ready), .clr(clr), .bus_pd_n(bus_pd_n), .spu_en(spu_en),
    .busy(busy), .done(done), .rx_bit(rx_bit)
  );
endmodule

// File: tb/test_swire_phy.sv
module test_swire_phy;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 4_000_000;
  localparam int US         = CLK_HZ / 1_000_000;
  localparam int HW         = 8;

  typedef struct {
    logic [2:0] op;
    bit         rx;
    int         low;
    int         spu;
    int         bsy;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_op = 3'd0;
  logic [HW-1:0] req_hold_us = '0;
  logic req_ready, done, rx_bit, busy, bus_pd_n, spu_en;
  logic pres_n = 1'b1, rd_n = 1'b1, force_low = 1'b0;
  bit present_en = 1'b1, rd_arm = 1'b0, rd_val = 1'b1;
  wire bus = bus_pd_n & pres_n & rd_n & !force_low;

  int checks = 0, errors = 0;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  swire_phy #(.CLK_HZ(CLK_HZ), .HOLD_W(HW)) i_swire_phy (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_hold_us(req_hold_us), .done(done), .rx_bit(rx_bit),
    .busy(busy), .bus_in(bus), .bus_pd_n(bus_pd_n), .spu_en(spu_en)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // slave presence answer after a long low
  initial begin
    forever begin
      int lowc;
      @(negedge bus_pd_n);
      lowc = 0;
      while (!bus_pd_n) begin @(posedge clk); lowc++; end
      if (lowc >= 400 * US && present_en) begin
        repeat (30 * US) @(posedge clk);
        pres_n = 1'b0;
        repeat (100 * US) @(posedge clk);
        pres_n = 1'b1;
      end
    end
  end

  // slave read answer: hold low 25 us for a 0
  initial begin
    forever begin
      @(negedge bus_pd_n);
      if (rd_arm && !rd_val) begin
        rd_n = 1'b0;
        repeat (25 * US) @(posedge clk);
        rd_n = 1'b1;
      end
    end
  end

  // monitor / scoreboard
  int bc = 0, lc = 0, sc = 0, ov = 0;
  bit done_d = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) bc++;
      if (!bus_pd_n) lc++;
      if (spu_en) sc++;
      if (!bus_pd_n && spu_en) ov++;
      if (done_d) check(!done, "R8", "done width", int'(done), 0);
      if (done) begin
        if (sb.size() == 0) begin
          check(1'b0, "R2", "unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(rx_bit == e.rx, e.tag, "rx_bit (R8)", int'(rx_bit), int'(e.rx));
          check(lc == e.low, e.tag, "low cycles (R10)", lc, e.low);
          check(sc == e.spu, e.tag, "spu cycles", sc, e.spu);
          check(bc == e.bsy, e.tag, "busy cycles (R10)", bc, e.bsy);
          check(ov == 0, "R9", "pull-down with strong pull-up", ov, 0);
        end
        bc = 0; lc = 0; sc = 0; ov = 0;
      end
      done_d = done;
    end
  end

  task automatic push(input logic [2:0] op, input int hold, input bit rx, input string tag);
    exp_t e;
    e.op = op; e.rx = rx; e.tag = tag; e.spu = 0; e.low = 0;
    case (op)
      3'd0: begin e.low = 480 * US; e.bsy = 960 * US; end
      3'd1: begin e.low = 60 * US;  e.bsy = 70 * US; end
      3'd2: begin e.low = 6 * US;   e.bsy = 70 * US; end
      3'd3: begin e.low = 2 * US;   e.bsy = 70 * US; end
      default: begin e.spu = (hold == 0) ? 1 : hold * US; e.bsy = e.spu; end
    endcase
    sb.push_back(e);
  endtask

  task automatic run_op(input logic [2:0] op, input int hold, input bit slv,
                        input bit rx, input string tag);
    push(op, hold, rx, tag);
    rd_val = slv;
    rd_arm = (op == 3'd3);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_hold_us = HW'(hold);
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    rd_arm = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(bus_pd_n == 1'b1, "R1", "bus_pd_n", int'(bus_pd_n), 1);
    check(spu_en == 1'b0, "R1", "spu_en", int'(spu_en), 0);
    check(busy == 1'b0, "R1", "busy", int'(busy), 0);
    check(done == 1'b0, "R1", "done", int'(done), 0);
    check(req_ready == 1'b1, "R1", "req_ready", int'(req_ready), 1);

    present_en = 1'b1;
    run_op(3'd0, 0, 1'b1, 1'b1, "R3 presence");
    present_en = 1'b0;
    run_op(3'd0, 0, 1'b1, 1'b0, "R3 absent");
    present_en = 1'b1;
    run_op(3'd2, 0, 1'b1, 1'b0, "R4 write1");
    run_op(3'd1, 0, 1'b1, 1'b0, "R5 write0");
    run_op(3'd3, 0, 1'b0, 1'b0, "R6 read0");
    run_op(3'd3, 0, 1'b1, 1'b1, "R6 read1");
    run_op(3'd4, 50, 1'b1, 1'b0, "R7 hold50");
    run_op(3'd4, 0, 1'b1, 1'b0, "R7 hold0");
    run_op(3'd7, 3, 1'b1, 1'b0, "R7 hold code7");

    // R2: request during a running slot is ignored
    push(3'd1, 0, 1'b0, "R2 busy-ignore");
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'd1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (20) @(negedge clk);
    check(req_ready == 1'b0, "R2", "ready while busy", int'(req_ready), 0);
    req_valid = 1'b1; req_op = 3'd3;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    repeat (10) @(negedge clk);
    check(busy == 1'b0, "R2", "busy after ignored request", int'(busy), 0);

    // R2: request while line held low is ignored
    force_low = 1'b1;
    repeat (5) @(negedge clk);
    check(req_ready == 1'b0, "R2", "ready with line low", int'(req_ready), 0);
    req_valid = 1'b1; req_op = 3'd2;
    repeat (10) @(negedge clk);
    check(busy == 1'b0, "R2", "busy with line low", int'(busy), 0);
    req_valid = 1'b0;
    force_low = 1'b0;
    repeat (5) @(negedge clk);
    check(req_ready == 1'b1, "R2", "ready after line high", int'(req_ready), 1);
    check(sb.size() == 0, "R8", "pending results", sb.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule